// File: doc/BRIEF.md
# Effective Address Generator

This block turns the decoded addressing fields of a memory operand into an effective offset and a default segment choice. It takes the mode, register/memory selector, scale, index and base fields, a raw displacement, the operand-width bit and an address-size flag. It drives two register-file read selects, one for a base register and one for an index register, and receives their contents back in the same cycle. It adds base, scaled index and displacement, and cuts the sum to 16 or 32 bits.

It covers the 16-bit form, with its fixed base/index pairs, and the 32-bit form, with or without a scale-index-base byte. It handles the irregular encodings of both forms: direct offsets that have no base register, the "no index" index code, and the stack-segment default that applies to stack-pointer and frame-pointer bases. A register-operand encoding gives a register-direct result instead of an address. A scaled "no index" gives an undefined flag. All results come out of one register stage.

Top module: `ea_gen`

## Requirements
- R1: After reset `out_valid` is 0 and all result outputs are 0. Every cycle with `in_valid` high gives `out_valid` high on the next cycle, with results for those inputs. A cycle with `in_valid` low gives `out_valid` low on the next cycle.
- R2: 16-bit form (`addr32`=0, `mode`≠11). The `rm` codes 0..7 select BX+SI, BX+DI, BP+SI, BP+DI, SI, DI, BP and BX. The register numbers are AX=0, CX=1, DX=2, BX=3, SP=4, BP=5, SI=6, DI=7, and only the low 16 bits of each register are used. The displacement depends on `mode`: 00 adds none, 01 adds `disp[7:0]` sign-extended, 10 adds `disp[15:0]`. The sum wraps modulo 2^16, and `ea[31:16]` is 0.
- R3: 16-bit form with `mode`=00 and `rm`=110 uses no register. `ea` is `disp[15:0]`, and `seg` is 00 (DS).
- R4: In 16-bit form, `seg` is 01 (SS) whenever BP is the base. It is 00 (DS) in every other case.
- R5: 32-bit form without a scale-index-base byte (`rm`≠100). The base is the register numbered `rm`. `mode` 00 adds no displacement, 01 adds `disp[7:0]` sign-extended, and 10 adds `disp`. `mode`=00 with `rm`=101 is a bare `disp` offset with `seg` 00. `rm`=101 with `mode` 01 or 10 is EBP plus displacement with `seg` 01. All sums wrap modulo 2^32.
- R6: With `addr32`=1, `mode`≠11 and `rm`=100, the scale-index-base fields apply. The result is base + index × 2^`scale` + displacement, so `scale` 00/01/10/11 multiplies by 1/2/4/8.
- R7: In scale-index-base form, `idx`=100 means no index term. If `scale` is also nonzero, `undef` is 1. In all other cases `undef` is 0.
- R8: In scale-index-base form, `base`=100 (ESP) gives `seg` 01. `base`=101 with `mode`=00 uses no base register, adds `disp`, and gives `seg` 00. `base`=101 with `mode` 01 or 10 uses EBP and gives `seg` 01. Every other base gives `seg` 00.
- R9: `mode`=11 gives `reg_direct`=1, with `ea`=0, `seg`=00 and `undef`=0. With `w`=1, `reg_num`=`rm` and `reg_hi`=0. With `w`=0, `reg_num`={0,`rm[1:0]`} and `reg_hi`=`rm[2]`, so codes 100..111 name the high bytes of registers 0..3. For memory modes, `reg_direct`, `reg_num` and `reg_hi` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input fields are valid this cycle |
| addr32 | input | 1 | 1 selects the 32-bit addressing form |
| mode | input | 2 | Addressing mode field |
| rm | input | 3 | Register/memory selector field |
| scale | input | 2 | Scale field of the scale-index-base byte |
| idx | input | 3 | Index field of the scale-index-base byte |
| base | input | 3 | Base field of the scale-index-base byte |
| w | input | 1 | Operand width bit (1 = full size) |
| disp | input | 32 | Raw displacement, low bytes used by mode |
| base_sel | output | 3 | Register number for the base read port |
| base_data | input | 32 | Contents of the register chosen by base_sel |
| index_sel | output | 3 | Register number for the index read port |
| index_data | input | 32 | Contents of the register chosen by index_sel |
| out_valid | output | 1 | Results below are valid |
| ea | output | 32 | Effective offset |
| seg | output | 2 | Default segment: 00 DS, 01 SS |
| reg_direct | output | 1 | Operand is a register, not memory |
| reg_num | output | 3 | Physical register number in register-direct case |
| reg_hi | output | 1 | Register-direct operand is a high byte |
| undef | output | 1 | Undefined scaled no-index encoding |

## Verification
The assertions assume that `base_data` and `index_data` return, in the same cycle, the registers named by the select outputs. They also assume that `in_valid` and the fields are stable across each clock edge. The bench keeps to these assumptions by modelling the register file as a combinational array indexed by the selects, and by changing every input only on the falling clock edge. The fields in the random part of the stimulus take every code, including scaled no-index encodings and register-direct modes, so the assertions are exercised over the whole encoding space.

// File: rtl/ea_gen.sv
module ea_gen #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          addr32,
  input  logic [1:0]    mode,
  input  logic [2:0]    rm,
  input  logic [1:0]    scale,
  input  logic [2:0]    idx,
  input  logic [2:0]    base,
  input  logic          w,
  input  logic [AW-1:0] disp,
  output logic [2:0]    base_sel,
  input  logic [AW-1:0] base_data,
  output logic [2:0]    index_sel,
  input  logic [AW-1:0] index_data,
  output logic          out_valid,
  output logic [AW-1:0] ea,
  output logic [1:0]    seg,
  output logic          reg_direct,
  output logic [2:0]    reg_num,
  output logic          reg_hi,
  output logic          undef
);
  localparam int HW = AW / 2;
  localparam logic [2:0] R_BX = 3'd3, R_SP = 3'd4, R_BP = 3'd5, R_SI = 3'd6, R_DI = 3'd7;

  logic is_reg, has_sib, direct;
  logic b_use, x_use;
  logic [2:0] b_sel, x_sel;
  logic [AW-1:0] b_term, x_term, d_term, sum;

  assign is_reg  = (mode == 2'b11);
  assign has_sib = addr32 && !is_reg && (rm == 3'b100);
  assign direct  = (mode == 2'b00) &&
                   (addr32 ? (has_sib ? base == 3'b101 : rm == 3'b101) : rm == 3'b110);

  always_comb begin
    b_use = 1'b0; x_use = 1'b0; b_sel = 3'd0; x_sel = 3'd0;
    if (!is_reg && !direct) begin
      if (!addr32) begin
        case (rm)
          3'd0: begin b_use = 1'b1; b_sel = R_BX; x_use = 1'b1; x_sel = R_SI; end
          3'd1: begin b_use = 1'b1; b_sel = R_BX; x_use = 1'b1; x_sel = R_DI; end
          3'd2: begin b_use = 1'b1; b_sel = R_BP; x_use = 1'b1; x_sel = R_SI; end
          3'd3: begin b_use = 1'b1; b_sel = R_BP; x_use = 1'b1; x_sel = R_DI; end
          3'd4: begin x_use = 1'b1; x_sel = R_SI; end
          3'd5: begin x_use = 1'b1; x_sel = R_DI; end
          3'd6: begin b_use = 1'b1; b_sel = R_BP; end
          default: begin b_use = 1'b1; b_sel = R_BX; end
        endcase
      end else if (has_sib) begin
        b_use = 1'b1; b_sel = base;
      end else begin
        b_use = 1'b1; b_sel = rm;
      end
    end
    if (has_sib && idx != R_SP) begin
      x_use = 1'b1; x_sel = idx;
    end
  end

  assign base_sel  = b_sel;
  assign index_sel = x_sel;

  always_comb begin
    case (mode)
      2'b01:   d_term = {{(AW-8){disp[7]}}, disp[7:0]};
      2'b10:   d_term = addr32 ? disp : {{HW{1'b0}}, disp[HW-1:0]};
      default: d_term = direct ? (addr32 ? disp : {{HW{1'b0}}, disp[HW-1:0]}) : '0;
    endcase
  end

  assign b_term = b_use ? base_data : '0;
  assign x_term = x_use ? (index_data << (has_sib ? scale : 2'b00)) : '0;
  assign sum    = b_term + x_term + d_term;

  logic [AW-1:0] ea_d;
  logic          ss_d, undef_d;
  logic [2:0]    rnum_d;
  logic          rhi_d;

  assign ea_d    = is_reg ? '0 : (addr32 ? sum : {{HW{1'b0}}, sum[HW-1:0]});
  assign ss_d    = b_use && (b_sel == R_BP || (addr32 && b_sel == R_SP));
  assign undef_d = has_sib && (idx == R_SP) && (scale != 2'b00);
  assign rnum_d  = !is_reg ? 3'd0 : (w ? rm : {1'b0, rm[1:0]});
  assign rhi_d   = is_reg && !w && rm[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      ea         <= '0;
      seg        <= 2'b00;
      reg_direct <= 1'b0;
      reg_num    <= 3'd0;
      reg_hi     <= 1'b0;
      undef      <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        ea         <= ea_d;
        seg        <= {1'b0, ss_d};
        reg_direct <= is_reg;
        reg_num    <= rnum_d;
        reg_hi     <= rhi_d;
        undef      <= undef_d;
      end
    end
  end
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          addr32,
  input logic [1:0]    mode,
  input logic [2:0]    rm,
  input logic [1:0]    scale,
  input logic [2:0]    idx,
  input logic [2:0]    base,
  input logic          w,
  input logic          out_valid,
  input logic [AW-1:0] ea,
  input logic [1:0]    seg,
  input logic          reg_direct,
  input logic [2:0]    reg_num,
  input logic          reg_hi,
  input logic          undef
);
  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_bubble_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_narrow_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !addr32) |=> (ea[AW-1:AW/2] == '0));
  assert_seg_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !seg[1]);
  assert_scaled_noindex_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && addr32 && mode != 2'b11 && rm == 3'b100 && idx == 3'b100 && scale != 2'b00) |=> undef);
  assert_esp_base_ss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && addr32 && mode != 2'b11 && rm == 3'b100 && base == 3'b100) |=> (seg == 2'b01));
  assert_reg_direct_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b11) |=> (reg_direct && ea == '0 && seg == 2'b00 && !undef));
  assert_mem_no_reg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode != 2'b11) |=> (!reg_direct && !reg_hi && reg_num == 3'd0));
  assert_hi_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b11 && !w) |=> (reg_hi == $past(rm[2]) && reg_num[2] == 1'b0));
endmodule

bind ea_gen ea_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .addr32(addr32), .mode(mode),
  .rm(rm), .scale(scale), .idx(idx), .base(base), .w(w), .out_valid(out_valid),
  .ea(ea), .seg(seg), .reg_direct(reg_direct), .reg_num(reg_num), .reg_hi(reg_hi),
  .undef(undef)
);

// File: tb/test_ea_gen.sv
module test_ea_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, addr32 = 1'b0, w = 1'b0;
  logic [1:0] mode = '0, scale = '0;
  logic [2:0] rm = '0, idx = '0, base = '0;
  logic [31:0] disp = '0;
  logic [2:0] base_sel, index_sel;
  logic [31:0] base_data, index_data;
  logic out_valid, reg_direct, reg_hi, undef;
  logic [31:0] ea;
  logic [1:0] seg;
  logic [2:0] reg_num;

  always #4 clk = ~clk;

  logic [31:0] rf [8];
  assign base_data  = rf[base_sel];
  assign index_data = rf[index_sel];

  ea_gen i_ea_gen (.*);

  typedef struct {
    logic [31:0] ea; logic [1:0] seg; logic rd; logic [2:0] rn; logic rh; logic un;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic a32, input logic [1:0] md, input logic [2:0] r,
                                 input logic [1:0] sc, input logic [2:0] ix, input logic [2:0] bs,
                                 input logic wb, input logic [31:0] d, input string tag);
    exp_t e;
    logic [31:0] dx, off;
    e.tag = tag; e.ea = 0; e.seg = 0; e.rd = 0; e.rn = 0; e.rh = 0; e.un = 0;
    dx = (md == 2'b01) ? 32'(signed'(d[7:0])) : (md == 2'b10) ? d : 32'd0;
    if (md == 2'b11) begin
      e.rd = 1;
      e.rn = wb ? r : r & 3'b011;
      e.rh = !wb && r >= 3'd4;
    end else if (!a32) begin
      logic [15:0] bx, bp, si, di;
      bx = rf[3][15:0]; bp = rf[5][15:0]; si = rf[6][15:0]; di = rf[7][15:0];
      case (r)
        0: off = bx + si;
        1: off = bx + di;
        2: off = bp + si;
        3: off = bp + di;
        4: off = si;
        5: off = di;
        6: off = (md == 2'b00) ? 32'd0 : bp;
        default: off = bx;
      endcase
      if (md == 2'b00 && r == 6) dx = d;
      e.seg = (r == 2 || r == 3 || (r == 6 && md != 2'b00)) ? 2'b01 : 2'b00;
      e.ea = {16'd0, 16'(off + dx)};
    end else if (r != 4) begin
      if (md == 2'b00 && r == 5) e.ea = d;
      else begin
        e.ea = rf[r] + dx;
        e.seg = (r == 5) ? 2'b01 : 2'b00;
      end
    end else begin
      logic [31:0] bb, xx;
      bb = (md == 2'b00 && bs == 5) ? 32'd0 : rf[bs];
      if (md == 2'b00 && bs == 5) dx = d;
      xx = (ix == 4) ? 32'd0 : rf[ix] * (32'd1 << sc);
      e.un = (ix == 4) && (sc != 0);
      e.seg = (bs == 4 || (bs == 5 && md != 2'b00)) ? 2'b01 : 2'b00;
      e.ea = bb + xx + dx;
    end
    return e;
  endfunction

  task automatic drive(input logic a32, input logic [1:0] md, input logic [2:0] r,
                       input logic [1:0] sc, input logic [2:0] ix, input logic [2:0] bs,
                       input logic wb, input logic [31:0] d, input string tag);
    q.push_back(model(a32, md, r, sc, ix, bs, wb, d, tag));
    in_valid = 1; addr32 = a32; mode = md; rm = r; scale = sc; idx = ix; base = bs; w = wb; disp = d;
    @(negedge clk);
  endtask

  task automatic idle();
    in_valid = 0;
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q.size() == 0) chk("R1", "unexpected out_valid", 32'd1, 32'd0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, "ea", ea, e.ea);
        chk(e.tag, "seg", 32'(seg), 32'(e.seg));
        chk(e.tag, "reg_direct", 32'(reg_direct), 32'(e.rd));
        chk(e.tag, "reg_num", 32'(reg_num), 32'(e.rn));
        chk(e.tag, "reg_hi", 32'(reg_hi), 32'(e.rh));
        chk(e.tag, "undef", 32'(undef), 32'(e.un));
      end
    end
  end

  initial begin
    rf[0] = 32'hFFFF_FF00; rf[1] = 32'h1111_0004; rf[2] = 32'h2222_0010; rf[3] = 32'h1234_FFF0;
    rf[4] = 32'h0000_8000; rf[5] = 32'h0000_A000; rf[6] = 32'h0000_0020; rf[7] = 32'h0000_0100;
    repeat (3) @(negedge clk);
    chk("R1", "reset out_valid", 32'(out_valid), 0);
    chk("R1", "reset ea", ea, 0);
    rst_n = 1;
    @(negedge clk);
    // R2 / R3 / R4 : 16-bit form
    drive(0, 2'b00, 3'd0, 0, 0, 0, 1, 32'h0, "R2");
    drive(0, 2'b01, 3'd1, 0, 0, 0, 1, 32'h80, "R2");
    drive(0, 2'b10, 3'd2, 0, 0, 0, 1, 32'hFFFF_1234, "R4");
    drive(0, 2'b00, 3'd6, 0, 0, 0, 1, 32'h1234_BEEF, "R3");
    drive(0, 2'b01, 3'd6, 0, 0, 0, 1, 32'h5, "R4");
    drive(0, 2'b00, 3'd3, 0, 0, 0, 1, 32'h0, "R4");
    drive(0, 2'b10, 3'd4, 2'b11, 0, 0, 1, 32'h0000_0010, "R2");
    drive(0, 2'b01, 3'd5, 0, 0, 0, 1, 32'hFF, "R2");
    drive(0, 2'b00, 3'd7, 0, 0, 0, 1, 32'h0, "R2");
    idle();
    chk("R1", "bubble out_valid", 32'(out_valid), 0);
    // R5 : 32-bit without index byte
    drive(1, 2'b10, 3'd0, 0, 0, 0, 1, 32'h200, "R5");
    drive(1, 2'b00, 3'd5, 0, 0, 0, 1, 32'hDEAD_BEEF, "R5");
    drive(1, 2'b01, 3'd5, 0, 0, 0, 1, 32'hF0, "R5");
    drive(1, 2'b00, 3'd3, 0, 0, 0, 1, 32'h0, "R5");
    // R6 / R7 / R8 : scale-index-base form
    drive(1, 2'b00, 3'd4, 2'b10, 3'd6, 3'd3, 1, 32'h0, "R6");
    drive(1, 2'b01, 3'd4, 2'b11, 3'd1, 3'd4, 1, 32'h7F, "R8");
    drive(1, 2'b00, 3'd4, 2'b01, 3'd7, 3'd5, 1, 32'h0001_0000, "R8");
    drive(1, 2'b10, 3'd4, 2'b00, 3'd4, 3'd5, 1, 32'h10, "R7");
    drive(1, 2'b00, 3'd4, 2'b10, 3'd4, 3'd2, 1, 32'h0, "R7");
    drive(1, 2'b10, 3'd4, 2'b00, 3'd2, 3'd0, 1, 32'h100, "R6");
    // R9 : register direct
    drive(1, 2'b11, 3'd5, 0, 0, 0, 1, 32'h0, "R9");
    drive(0, 2'b11, 3'd5, 0, 0, 0, 0, 32'h0, "R9");
    drive(1, 2'b11, 3'd4, 2'b11, 3'd4, 0, 0, 32'h0, "R9");
    drive(0, 2'b11, 3'd2, 0, 0, 0, 0, 32'h0, "R9");
    idle();
    for (int n = 0; n < 400; n++) begin
      logic [31:0] v;
      v = $urandom;
      drive(v[0], v[2:1], v[5:3], v[7:6], v[10:8], v[13:11], v[14], $urandom, "R6");
      if (v[15] && v[16]) idle();
    end
    idle(); idle();
    chk("R1", "queue drained", q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule